// File: doc/BRIEF.md
# Watch Timekeeping Counter Chain

This block keeps the time of day for a digital watch. It runs entirely from the 32.768 kHz crystal clock. A binary prescaler with `DIV_STAGES` stages wraps once per second. Each wrap steps a cascade of BCD digit counters: seconds, then minutes, then hours. Hours run 1 to 12, and the reset time is 12:00:00. Every stage is a synchronous register advanced by a one-cycle enable, so the block has no ripple clocks.

The time is set with three buttons.

- Holding the fast-set button forces seconds to 00. Minutes then advance at a rate taken from an earlier prescaler stage: stage 8, or 128 Hz, by default. The minute wrap carries into hours.
- The minute button advances minutes by one per press.
- The hour button advances hours by one per press.

Each button passes through a two-flop synchronizer before it is used. The two step buttons are also edge-detected, so one press gives one step. The full prescaler state is brought out as taps for a display scanner.

Top module: `watch_chain`

## Requirements
- R1: While `rst` is high at a clock edge, the time becomes 12:00:00 (hr_tens=1, hr_units=2, all other digits 0), `div_taps` becomes 0 and the synchronizers clear.
- R2: `div_taps` increases by one on every clock and wraps from all-ones to zero. The seconds tick is the cycle in which `div_taps` is all-ones, so it occurs once every 2^DIV_STAGES cycles.
- R3: On a seconds tick, seconds advance. The units digit counts 0..9 and the tens digit counts 0..5. Going from 59 to 00 carries one minute.
- R4: Minutes count the same way as seconds. A seconds carry from minute 59 wraps minutes to 00 and carries one hour.
- R5: Hours are BCD 1..12 (hr_tens 0 or 1). 12:59:59 is followed by 01:00:00, and 11:59:59 by 12:00:00.
- R6: While synchronized fast-set is high, seconds are held at 00. The seconds tick is ignored. Minutes advance, with carry into hours, in every cycle where the low FAST_TAP bits of `div_taps` are all ones.
- R7: A synchronized rising edge of `min_set` advances minutes by one. 59 wraps to 00 with no change to hours, and seconds are unchanged.
- R8: A synchronized rising edge of `hour_set` advances hours by one. 12 wraps to 1, and minutes are unchanged.
- R9: A set input sampled at clock edge k takes effect at edge k+2. Holding `min_set` or `hour_set` high for many cycles gives exactly one step.
- R10: Fast-set has priority over the step buttons, and the buttons have priority over the seconds tick. A seconds tick in a cycle with a step is dropped. Step edges seen while fast-set is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_set | input | 1 | Fast-set button (asynchronous level) |
| hour_set | input | 1 | Hour step button (asynchronous) |
| min_set | input | 1 | Minute step button (asynchronous) |
| hr_tens | output | 4 | Hours tens digit, BCD |
| hr_units | output | 4 | Hours units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| min_units | output | 4 | Minutes units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| sec_units | output | 4 | Seconds units digit, BCD |
| div_taps | output | DIV_STAGES | Prescaler state, one bit per divider stage |

## Verification
The assertions assume that the synchronized buttons change slowly compared with the clock. In particular, the no-carry checks assume that no step pulse coincides with a fast-set change. The bench therefore holds each press for four cycles and releases it for four. It drives all inputs on the falling edge, so the synchronizer always captures a settled value.

The prescaler is shortened in the bench so that the hour rollover is reached within the run. Fast-set is held across an hour boundary, and a minute press is made during fast-set to exercise the priority rule.

// File: rtl/watch_pkg.sv
package watch_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t ht;
        digit_t hu;
        digit_t mt;
        digit_t mu;
        digit_t st;
        digit_t su;
    } wtime_t;

    localparam wtime_t RESET_TIME = '{ht: 4'd1, hu: 4'd2, mt: 4'd0, mu: 4'd0, st: 4'd0, su: 4'd0};

    // Step a BCD digit that wraps after 'last'
    function automatic digit_t bcd_inc(input digit_t d, input digit_t last);
        return (d == last) ? '0 : d + 4'd1;
    endfunction

    // Step a 1..12 hour field held as two BCD digits
    function automatic logic [2*DIGIT_W-1:0] hour_inc(input digit_t t, input digit_t u);
        if (t == 4'd1 && u == 4'd2) return {4'd0, 4'd1};
        if (u == 4'd9)              return {4'd1, 4'd0};
        return {t, u + 4'd1};
    endfunction

endpackage

// File: rtl/watch_prescaler.sv
module watch_prescaler #(
    parameter int DIV_STAGES = 15,
    parameter int FAST_TAP   = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic [DIV_STAGES-1:0] taps,
    output logic                  sec_tick,
    output logic                  fast_tick
);
    logic [DIV_STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q + 1'b1;
    end

    assign taps      = q;
    assign sec_tick  = &q;
    assign fast_tick = &q[FAST_TAP-1:0];

    // R2: the seconds tick is always also a fast tick
    a_r2_tick_nest: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> fast_tick);

    // R2: the prescaler moves by exactly one per clock
    a_r2_taps_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (taps == $past(taps) + 1'b1));
endmodule

// File: rtl/watch_btn_sync.sv
module watch_btn_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign level = s2;
    assign rise  = s2 & ~s3;

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R9: a held press yields a single one-cycle step
        a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/watch_time_chain.sv
module watch_time_chain
    import watch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sec_tick,
    input  logic   fast_tick,
    input  logic   fast_lvl,
    input  logic   hr_step,
    input  logic   mn_step,
    output wtime_t cur
);
    wtime_t nxt;
    logic   sec_wrap, min_wrap;
    logic [2*DIGIT_W-1:0] hr_n;
    digit_t mu_n, mt_n, su_n, st_n;

    always_comb begin
        sec_wrap = (cur.st == 4'd5) && (cur.su == 4'd9);
        min_wrap = (cur.mt == 4'd5) && (cur.mu == 4'd9);
        su_n     = bcd_inc(cur.su, 4'd9);
        st_n     = (cur.su == 4'd9) ? bcd_inc(cur.st, 4'd5) : cur.st;
        mu_n     = bcd_inc(cur.mu, 4'd9);
        mt_n     = (cur.mu == 4'd9) ? bcd_inc(cur.mt, 4'd5) : cur.mt;
        hr_n     = hour_inc(cur.ht, cur.hu);

        nxt = cur;
        if (fast_lvl) begin
            nxt.st = '0;
            nxt.su = '0;
            if (fast_tick) begin
                nxt.mu = mu_n;
                nxt.mt = mt_n;
                if (min_wrap) {nxt.ht, nxt.hu} = hr_n;
            end
        end else if (mn_step || hr_step) begin
            if (mn_step) begin
                nxt.mu = mu_n;
                nxt.mt = mt_n;
            end
            if (hr_step) {nxt.ht, nxt.hu} = hr_n;
        end else if (sec_tick) begin
            nxt.su = su_n;
            nxt.st = st_n;
            if (sec_wrap) begin
                nxt.mu = mu_n;
                nxt.mt = mt_n;
                if (min_wrap) {nxt.ht, nxt.hu} = hr_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= RESET_TIME;
        else     cur <= nxt;
    end

    a_r3_sec_digits: assert property (@(posedge clk) disable iff (rst)
        (cur.su <= 4'd9) && (cur.st <= 4'd5));

    a_r4_min_digits: assert property (@(posedge clk) disable iff (rst)
        (cur.mu <= 4'd9) && (cur.mt <= 4'd5));

    a_r5_hour_range: assert property (@(posedge clk) disable iff (rst)
        ((cur.ht == 4'd0) && (cur.hu != 4'd0) && (cur.hu <= 4'd9)) ||
        ((cur.ht == 4'd1) && (cur.hu <= 4'd2)));

    a_r5_noon_wrap: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !fast_lvl && !mn_step && !hr_step &&
         cur == '{ht: 4'd1, hu: 4'd2, mt: 4'd5, mu: 4'd9, st: 4'd5, su: 4'd9})
        |=> (cur == '{ht: 4'd0, hu: 4'd1, mt: 4'd0, mu: 4'd0, st: 4'd0, su: 4'd0}));

    a_r6_fast_clears_sec: assert property (@(posedge clk) disable iff (rst)
        fast_lvl |=> (cur.st == 4'd0) && (cur.su == 4'd0));

    a_r7_min_no_carry: assert property (@(posedge clk) disable iff (rst)
        (mn_step && !hr_step && !fast_lvl) |=> $stable(cur.ht) && $stable(cur.hu) && $stable(cur.su));

    a_r8_hour_only: assert property (@(posedge clk) disable iff (rst)
        (hr_step && !mn_step && !fast_lvl) |=> $stable(cur.mt) && $stable(cur.mu));
endmodule

// File: rtl/watch_chain.sv
module watch_chain
    import watch_pkg::*;
#(
    parameter int DIV_STAGES = 15,
    parameter int FAST_TAP   = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fast_set,
    input  logic                  hour_set,
    input  logic                  min_set,
    output logic [3:0]            hr_tens,
    output logic [3:0]            hr_units,
    output logic [3:0]            min_tens,
    output logic [3:0]            min_units,
    output logic [3:0]            sec_tens,
    output logic [3:0]            sec_units,
    output logic [DIV_STAGES-1:0] div_taps
);
    localparam int BTN_N = 3;

    logic             sec_tick, fast_tick;
    logic [BTN_N-1:0] lvl, rise;
    wtime_t           now;

    watch_prescaler #(.DIV_STAGES(DIV_STAGES), .FAST_TAP(FAST_TAP)) u_div (
        .clk       (clk),
        .rst       (rst),
        .taps      (div_taps),
        .sec_tick  (sec_tick),
        .fast_tick (fast_tick)
    );

    watch_btn_sync #(.W(BTN_N)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   ({fast_set, hour_set, min_set}),
        .level (lvl),
        .rise  (rise)
    );

    watch_time_chain u_time (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .fast_tick (fast_tick),
        .fast_lvl  (lvl[2]),
        .hr_step   (rise[1]),
        .mn_step   (rise[0]),
        .cur       (now)
    );

    assign hr_tens   = now.ht;
    assign hr_units  = now.hu;
    assign min_tens  = now.mt;
    assign min_units = now.mu;
    assign sec_tens  = now.st;
    assign sec_units = now.su;
endmodule

// File: tb/watch_chain_tb_top.sv
module watch_chain_tb_top;
    localparam int NST   = 6;
    localparam int FT    = 3;
    localparam int SPAN  = 1 << NST;
    localparam int FSPAN = 1 << FT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fast_set = 1'b0, hour_set = 1'b0, min_set = 1'b0;
    logic [3:0] hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units;
    logic [NST-1:0] div_taps;

    always #4 clk = ~clk;   // 125 MHz

    watch_chain #(.DIV_STAGES(NST), .FAST_TAP(FT)) dut_i (
        .clk(clk), .rst(rst), .fast_set(fast_set), .hour_set(hour_set), .min_set(min_set),
        .hr_tens(hr_tens), .hr_units(hr_units), .min_tens(min_tens), .min_units(min_units),
        .sec_tens(sec_tens), .sec_units(sec_units), .div_taps(div_taps)
    );

    int vectors = 0, miscompares = 0;
    int div, h, m, s;
    bit f1, f2, f3, hp1, hp2, hp3, mp1, mp2, mp3;
    bit started = 0;

    // Reference model: behaviour of R1..R10 with integers
    always @(posedge clk) begin
        if (rst) begin
            div = 0; h = 12; m = 0; s = 0;
            {f1, f2, f3, hp1, hp2, hp3, mp1, mp2, mp3} = '0;
        end else begin
            bit fe, hs, ms, st, ft;
            fe = f2;                // R9: two-edge latency
            hs = hp2 && !hp3;
            ms = mp2 && !mp3;
            st = (div == SPAN - 1);
            ft = (div % FSPAN == FSPAN - 1);
            div = (div + 1) % SPAN;
            if (fe) begin           // R10 priority: fast first
                s = 0;
                if (ft) begin
                    m++;
                    if (m == 60) begin m = 0; h = h % 12 + 1; end
                end
            end else if (hs || ms) begin
                if (ms) m = (m + 1) % 60;
                if (hs) h = h % 12 + 1;
            end else if (st) begin
                s++;
                if (s == 60) begin
                    s = 0; m++;
                    if (m == 60) begin m = 0; h = h % 12 + 1; end
                end
            end
            f3 = f2; f2 = f1; f1 = fast_set;
            hp3 = hp2; hp2 = hp1; hp1 = hour_set;
            mp3 = mp2; mp2 = mp1; mp1 = min_set;
        end
        started = 1;
    end

    task automatic cmp(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    function automatic int dut_h();   return hr_tens * 10 + hr_units;   endfunction
    function automatic int dut_m();   return min_tens * 10 + min_units; endfunction
    function automatic int dut_s();   return sec_tens * 10 + sec_units; endfunction

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            cmp("R2 taps",  int'(div_taps), div);
            cmp("R3 sec",   dut_s(), s);
            cmp("R4 min",   dut_m(), m);
            cmp("R5 hour",  dut_h(), h);
        end
    end

    task automatic press(ref logic b);
        b = 1'b1; repeat (4) @(negedge clk);
        b = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1 hour", dut_h(), 12);
        cmp("R1 min",  dut_m(), 0);
        cmp("R1 sec",  dut_s(), 0);
        cmp("R1 taps", int'(div_taps), 0);
        rst = 1'b0;

        // R3/R4 seconds carry into minutes
        repeat (70 * SPAN) @(negedge clk);
        cmp("R3 sec after 70s", dut_s(), 10);
        cmp("R4 min after 70s", dut_m(), 1);

        // R7 minute steps and wrap without hour carry
        for (int i = 0; i < 58; i++) press(min_set);
        cmp("R7 min 59", dut_m(), 59);
        press(min_set);
        cmp("R7 min wrap", dut_m(), 0);
        cmp("R7 no hour carry", dut_h(), 12);
        for (int i = 0; i < 59; i++) press(min_set);

        // R5 12:59:xx rolls to 01:00:xx
        repeat (61 * SPAN) @(negedge clk);
        cmp("R5 hour 1", dut_h(), 1);
        cmp("R5 min 0",  dut_m(), 0);

        // R8 hour steps and 12 -> 1 wrap
        for (int i = 0; i < 11; i++) press(hour_set);
        cmp("R8 hour 12", dut_h(), 12);
        press(hour_set);
        cmp("R8 hour wrap", dut_h(), 1);
        cmp("R8 min kept", dut_m(), m);

        // R9 a long hold gives one step; latency check
        hour_set = 1'b1;
        @(negedge clk); @(negedge clk);
        cmp("R9 no step yet", dut_h(), 1);
        repeat (40) @(negedge clk);
        hour_set = 1'b0;
        repeat (4) @(negedge clk);
        cmp("R9 single step", dut_h(), 2);

        // R6 fast set across an hour boundary
        fast_set = 1'b1;
        repeat (500) @(negedge clk);
        cmp("R6 sec held", dut_s(), 0);
        // R10 minute press during fast set is ignored
        press(min_set);
        repeat (500) @(negedge clk);
        cmp("R10 min", dut_m(), m);
        cmp("R6 hour", dut_h(), h);
        fast_set = 1'b0;
        repeat (5 * SPAN) @(negedge clk);
        cmp("R6 sec resumes", dut_s(), s);
        cmp("R2 taps end", int'(div_taps), div);
        finish_run();
    end
endmodule